// File: doc/BRIEF.md
# Interrupt and Card-Detect Controller

This block holds the interrupt state for a card reader's bulk-data path and its socket. A single 32-bit word carries seven latched event flags, their seven enables sixteen positions higher, and two live read-only levels: whether a card sits in the socket, and the state of the activity lamp. Event sources raise one-cycle pulses. The block latches each pulse into its flag and keeps the flag until software clears it. A single interrupt line is raised whenever any latched flag has its enable set.

Software writes the whole word. A zero written into an event position acknowledges that event. A one written there leaves the flag as it is, so software can acknowledge one flag by writing back the value it read with only that bit cleared. The enable positions are plain storage. The two live positions and every unassigned position ignore writes.

The underrun flag has no pulse input of its own. It is raised when a read strobe for the bulk FIFO arrives while the FIFO reports empty.

Top module: `icd_ctrl`

## Requirements
- R1: After reset every event flag and every enable reads 0 and irq_o is low.
- R2: Bit 1 of the word always shows the current card-present input and bit 15 the current lamp input; every bit other than 1, 8..14, 15 and 24..30 reads 0.
- R3: The event positions are bit 8 insert, bit 9 removal, bit 10 FIFO empty, bit 11 DMA done, bit 12 underrun, bit 13 length mismatch and bit 14 DMA error. A pulse on a source sets its bit at the next clock edge, and the bit then stays set.
- R4: Bit 12 sets only in a cycle where fifo_rd_i and fifo_empty_i are both high; either one alone does not set it.
- R5: A write with 0 in an event position clears that flag at the next edge. A write with 1 there leaves the flag unchanged and never sets it.
- R6: An event pulse that arrives in the same cycle as a write clearing its flag leaves the flag set.
- R7: Bits 24..30 hold the enables for bits 8..14 and take the written value on every write. Writes to bits 1, 15 and the unassigned bits have no effect.
- R8: irq_o is high exactly when some event bit in 8..14 and the enable 16 positions above it are both set, and it follows the register contents with no added delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read value |
| present_i | input | 1 | Card-present level |
| led_i | input | 1 | Lamp state level |
| evt_insert_i | input | 1 | Card inserted pulse |
| evt_remove_i | input | 1 | Card removed pulse |
| evt_empty_i | input | 1 | FIFO became empty pulse |
| evt_dma_done_i | input | 1 | DMA finished pulse |
| evt_mismatch_i | input | 1 | Data count differs from the commanded length pulse |
| evt_dma_err_i | input | 1 | DMA I/O failure pulse |
| fifo_rd_i | input | 1 | Read strobe on the bulk FIFO |
| fifo_empty_i | input | 1 | Bulk FIFO empty level |
| irq_o | output | 1 | Interrupt request |

## Verification
The case that needs care is a software acknowledge and a hardware event landing on the same flag in the same cycle. The bench provokes it for each of the seven flags, underrun included, by driving the clearing write and the pulse (or the read-while-empty pair) on one clock edge. The flag must still read set afterwards, and a plain clear in a later cycle must then remove it. Write-one-keeps is tested the same way: a write of all ones is placed next to a pending flag, and the flag must neither drop nor appear when it was clear.

// File: rtl/icd_pkg.sv
package icd_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned EVT_N    = 7;
  localparam int unsigned EVT_LSB  = 8;
  localparam int unsigned EN_OFS   = 16;
  localparam int unsigned PRES_BIT = 1;
  localparam int unsigned LED_BIT  = 15;

  // event slot order is software-visible
  localparam int unsigned EV_INSERT   = 0;
  localparam int unsigned EV_REMOVE   = 1;
  localparam int unsigned EV_EMPTY    = 2;
  localparam int unsigned EV_DMA_DONE = 3;
  localparam int unsigned EV_UNDERRUN = 4;
  localparam int unsigned EV_MISMATCH = 5;
  localparam int unsigned EV_DMA_ERR  = 6;
endpackage

// File: rtl/icd_evt_src.sv
module icd_evt_src
  import icd_pkg::*;
#(
  parameter int unsigned N = EVT_N
) (
  input  logic         evt_insert_i,
  input  logic         evt_remove_i,
  input  logic         evt_empty_i,
  input  logic         evt_dma_done_i,
  input  logic         evt_mismatch_i,
  input  logic         evt_dma_err_i,
  input  logic         fifo_rd_i,
  input  logic         fifo_empty_i,
  output logic [N-1:0] raise_o
);
  always_comb begin
    raise_o              = '0;
    raise_o[EV_INSERT]   = evt_insert_i;
    raise_o[EV_REMOVE]   = evt_remove_i;
    raise_o[EV_EMPTY]    = evt_empty_i;
    raise_o[EV_DMA_DONE] = evt_dma_done_i;
    // underrun: read attempted while nothing is queued
    raise_o[EV_UNDERRUN] = fifo_rd_i & fifo_empty_i;
    raise_o[EV_MISMATCH] = evt_mismatch_i;
    raise_o[EV_DMA_ERR]  = evt_dma_err_i;
  end
endmodule

// File: rtl/icd_evt_cell.sv
module icd_evt_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raise_i,
  input  logic clr_i,
  output logic q_o
);
  // raise wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= raise_i | (q_o & ~clr_i);
  end
endmodule

// File: rtl/icd_evt_bank.sv
module icd_evt_bank #(
  parameter int unsigned N = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] raise_i,
  input  logic         wr_i,
  input  logic [N-1:0] keep_i,
  input  logic [N-1:0] en_d_i,
  output logic [N-1:0] evt_o,
  output logic [N-1:0] en_o
);
  for (genvar g = 0; g < N; g++) begin : g_slot
    icd_evt_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .raise_i(raise_i[g]),
      .clr_i  (wr_i & ~keep_i[g]),
      .q_o    (evt_o[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   en_o <= '0;
    else if (wr_i) en_o <= en_d_i;
  end
endmodule

// File: rtl/icd_irq_comb.sv
module icd_irq_comb #(
  parameter int unsigned N = 7
) (
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] en_i,
  output logic         irq_o
);
  assign irq_o = |(evt_i & en_i);
endmodule

// File: rtl/icd_ctrl.sv
module icd_ctrl
  import icd_pkg::*;
#(
  parameter int unsigned W        = REG_W,
  parameter int unsigned N        = EVT_N,
  parameter int unsigned LSB      = EVT_LSB,
  parameter int unsigned OFS      = EN_OFS,
  parameter int unsigned PRES_POS = PRES_BIT,
  parameter int unsigned LED_POS  = LED_BIT
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         reg_we_i,
  input  logic [W-1:0] reg_wdata_i,
  output logic [W-1:0] reg_rdata_o,
  input  logic         present_i,
  input  logic         led_i,
  input  logic         evt_insert_i,
  input  logic         evt_remove_i,
  input  logic         evt_empty_i,
  input  logic         evt_dma_done_i,
  input  logic         evt_mismatch_i,
  input  logic         evt_dma_err_i,
  input  logic         fifo_rd_i,
  input  logic         fifo_empty_i,
  output logic         irq_o
);
  localparam int unsigned EN_LSB = LSB + OFS;

  logic [N-1:0] raise, evt_q, en_q;

  icd_evt_src #(.N(N)) u_src (
    .evt_insert_i  (evt_insert_i),
    .evt_remove_i  (evt_remove_i),
    .evt_empty_i   (evt_empty_i),
    .evt_dma_done_i(evt_dma_done_i),
    .evt_mismatch_i(evt_mismatch_i),
    .evt_dma_err_i (evt_dma_err_i),
    .fifo_rd_i     (fifo_rd_i),
    .fifo_empty_i  (fifo_empty_i),
    .raise_o       (raise)
  );

  icd_evt_bank #(.N(N)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raise_i(raise),
    .wr_i   (reg_we_i),
    .keep_i (reg_wdata_i[LSB +: N]),
    .en_d_i (reg_wdata_i[EN_LSB +: N]),
    .evt_o  (evt_q),
    .en_o   (en_q)
  );

  icd_irq_comb #(.N(N)) u_irq (
    .evt_i(evt_q),
    .en_i (en_q),
    .irq_o(irq_o)
  );

  always_comb begin
    reg_rdata_o               = '0;
    reg_rdata_o[PRES_POS]     = present_i;
    reg_rdata_o[LED_POS]      = led_i;
    reg_rdata_o[LSB +: N]     = evt_q;
    reg_rdata_o[EN_LSB +: N]  = en_q;
  end

  logic unused_wdata;
  assign unused_wdata = ^{reg_wdata_i[LSB-1:0], reg_wdata_i[EN_LSB-1:LSB+N], reg_wdata_i[W-1:EN_LSB+N]};
endmodule

// File: rtl/icd_ctrl_chk.sv
module icd_ctrl_chk #(
  parameter int unsigned W   = 32,
  parameter int unsigned LSB = 8,
  parameter int unsigned OFS = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         reg_we_i,
  input logic [W-1:0] reg_wdata_i,
  input logic [W-1:0] reg_rdata_o,
  input logic         evt_insert_i,
  input logic         evt_remove_i,
  input logic         evt_dma_done_i,
  input logic         fifo_rd_i,
  input logic         fifo_empty_i,
  input logic         irq_o
);
  localparam logic [W-1:0] UNUSED_MASK = ~32'h7F00_FF02;

  assert_unused_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o & UNUSED_MASK) == '0);

  assert_insert_sets_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_insert_i |=> reg_rdata_o[LSB]);

  assert_underrun_gated_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(fifo_rd_i && fifo_empty_i) && !reg_rdata_o[LSB+4]) |=> !reg_rdata_o[LSB+4]);

  assert_hold_no_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reg_we_i && reg_rdata_o[LSB+3]) |=> reg_rdata_o[LSB+3]);

  assert_clear_on_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !reg_wdata_i[LSB] && !evt_insert_i) |=> !reg_rdata_o[LSB]);

  assert_raise_beats_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !reg_wdata_i[LSB+1] && evt_remove_i) |=> reg_rdata_o[LSB+1]);

  assert_enable_written_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i |=> reg_rdata_o[LSB+OFS +: 7] == $past(reg_wdata_i[LSB+OFS +: 7]));

  assert_irq_matches_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == |(reg_rdata_o[LSB +: 7] & reg_rdata_o[LSB+OFS +: 7]));

  logic unused_chk;
  assign unused_chk = evt_dma_done_i;
endmodule

bind icd_ctrl icd_ctrl_chk #(.W(W), .LSB(LSB), .OFS(OFS)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .reg_we_i      (reg_we_i),
  .reg_wdata_i   (reg_wdata_i),
  .reg_rdata_o   (reg_rdata_o),
  .evt_insert_i  (evt_insert_i),
  .evt_remove_i  (evt_remove_i),
  .evt_dma_done_i(evt_dma_done_i),
  .fifo_rd_i     (fifo_rd_i),
  .fifo_empty_i  (fifo_empty_i),
  .irq_o         (irq_o)
);

// File: tb/icd_ctrl_bench.sv
module icd_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 50000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        present_i = 1'b0, led_i = 1'b0;
  logic        evt_insert_i = 0, evt_remove_i = 0, evt_empty_i = 0;
  logic        evt_dma_done_i = 0, evt_mismatch_i = 0, evt_dma_err_i = 0;
  logic        fifo_rd_i = 0, fifo_empty_i = 0;
  logic        irq_o;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [6:0] m_evt = '0, m_en = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  icd_ctrl u_icd_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .present_i(present_i), .led_i(led_i),
    .evt_insert_i(evt_insert_i), .evt_remove_i(evt_remove_i), .evt_empty_i(evt_empty_i),
    .evt_dma_done_i(evt_dma_done_i), .evt_mismatch_i(evt_mismatch_i),
    .evt_dma_err_i(evt_dma_err_i), .fifo_rd_i(fifo_rd_i), .fifo_empty_i(fifo_empty_i),
    .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word();
    logic [31:0] w = '0;
    w[1] = present_i;
    w[15] = led_i;
    w[14:8] = m_evt;
    w[30:24] = m_en;
    return w;
  endfunction

  task automatic check_all(input string tag);
    check({tag, " word"}, reg_rdata_o, exp_word());
    check({tag, " irq R8"}, {31'b0, irq_o}, {31'b0, |(m_evt & m_en)});
  endtask

  // bit 4 of p drives nothing; underrun comes from rd and emp
  task automatic step(input string tag, input bit we, input logic [31:0] wd,
                      input logic [6:0] p, input bit rd, input bit emp);
    logic [6:0] raise;
    reg_we_i = we; reg_wdata_i = wd;
    evt_insert_i = p[0]; evt_remove_i = p[1]; evt_empty_i = p[2];
    evt_dma_done_i = p[3]; evt_mismatch_i = p[5]; evt_dma_err_i = p[6];
    fifo_rd_i = rd; fifo_empty_i = emp;
    raise = (p & 7'b1101111) | {2'b0, rd & emp, 4'b0};
    @(posedge clk);
    m_evt = (we ? (m_evt & wd[14:8]) : m_evt) | raise;
    if (we) m_en = wd[30:24];
    @(negedge clk);
    reg_we_i = 0; reg_wdata_i = '0;
    {evt_insert_i, evt_remove_i, evt_empty_i, evt_dma_done_i, evt_mismatch_i, evt_dma_err_i} = '0;
    fifo_rd_i = 0; fifo_empty_i = 0;
    check_all(tag);
  endtask

  task automatic raise_slot(input string tag, input int i, input bit we, input logic [31:0] wd);
    if (i == 4) step(tag, we, wd, 7'b0, 1'b1, 1'b1);
    else        step(tag, we, wd, 7'(1 << i), 1'b0, 1'b0);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_all("R1 in reset");
    rst_ni = 1'b1;
    @(negedge clk);
    check_all("R1 after reset");

    for (int k = 0; k < 4; k++) begin
      present_i = k[0]; led_i = k[1];
      step("R2 live bits", 1'b0, '0, '0, 1'b0, 1'b0);
    end
    present_i = 1'b1; led_i = 1'b0;

    step("R7 R5 write all ones", 1'b1, 32'hFFFF_FFFF, '0, 1'b0, 1'b0);
    step("R7 write zero", 1'b1, 32'h0000_0000, '0, 1'b0, 1'b0);
    step("R7 pattern", 1'b1, 32'hAA55_8002, '0, 1'b0, 1'b0);

    for (int i = 0; i < 7; i++) begin
      raise_slot("R3 set", i, 1'b0, '0);
      step("R3 hold", 1'b0, '0, '0, 1'b0, 1'b0);
      step("R5 write one keeps", 1'b1, 32'hFFFF_FFFF, '0, 1'b0, 1'b0);
      step("R5 clear", 1'b1, ~(32'h1 << (8 + i)), '0, 1'b0, 1'b0);
      raise_slot("R3 reset again", i, 1'b0, '0);
      raise_slot("R6 raise with clear", i, 1'b1, ~(32'h1 << (8 + i)));
      step("R5 clear after R6", 1'b1, 32'h0, '0, 1'b0, 1'b0);
    end

    step("R4 read only", 1'b0, '0, '0, 1'b1, 1'b0);
    step("R4 empty only", 1'b0, '0, '0, 1'b0, 1'b1);
    step("R4 both", 1'b0, '0, '0, 1'b1, 1'b1);

    step("R8 all set", 1'b0, '0, 7'h7F, 1'b1, 1'b1);
    for (int e = 0; e < 128; e++)
      step("R8 enable sweep", 1'b1, {1'b0, 7'(e), 9'b0, 7'h7F, 8'b0}, '0, 1'b0, 1'b0);

    for (int v = 0; v < 128; v++) begin
      logic [6:0] en = 7'(v * 37 + 11);
      step("R5 clear all", 1'b1, {1'b0, en, 24'b0}, '0, 1'b0, 1'b0);
      step("R8 event sweep", 1'b0, '0, 7'(v), v[4], v[4]);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule